// File: doc/BRIEF.md
# Noisy Cell Qualification Checker

This block decides whether one storage cell has been pushed into a usable noisy state, partway between erased and programmed. A controller pulses `start` with four values: the trace length, the retry budget, a back-off value, and the step count recorded when the cell was first spotted. The block first asks for a run of preload partial-program steps. It then works through attempts. Each attempt asks for one more program step, takes in a trace of read samples from the cell, and judges that trace.

A trace is judged in two ways. The first test rejects a cell that is almost stuck at one level. The second test runs a sliding-window count of ones over the trace and requires the window average to rise high at some point and fall low at some point. The first attempt that passes both tests ends the job with a pass pulse. If the retry budget runs out first, the job ends with a fail pulse.

Samples arrive on a valid/ready stream. A sample is transferred on a rising clock edge where `smp_valid` and `smp_ready` are both high. The block asserts `smp_ready` only while it is collecting a trace, so the source may hold a sample for as long as it likes and may insert idle cycles freely. The program request is a plain one-cycle strobe. The block does not wait for any acknowledge.

Top module: `nq_cell_qualify`

## Requirements
- R1: A `start` pulse seen while `busy` is low captures `n_samples`, `retry_limit`, `step_offset` and `step_record`, and `busy` rises on the next cycle. A `start` seen while `busy` is high is ignored and leaves the job running unchanged.
- R2: Before the first attempt, the block issues max(`step_record` − `step_offset`, 0) preload requests on `prog_req`, each one cycle long.
- R3: Every attempt begins with exactly one `prog_req` cycle. The block then accepts exactly `n_samples` samples, one per cycle in which `smp_valid` and `smp_ready` are both high. `smp_ready` is low whenever the block is not collecting.
- R4: A trace fails when ones×100 > 98×N or zeros×100 > 98×N, where N is the number of samples. A trace with exactly 98% of one value is not rejected by this test.
- R5: The window sum is the number of ones among the last W accepted samples of the current trace. Its maximum and minimum are tracked only from the W-th sample onward, and a trace shorter than W fails.
- R6: A trace passes only when max×10 > 7×W, min×10 < 3×W, and R4 does not reject it.
- R7: A passing trace produces a one-cycle `pass_pulse`. No further `prog_req` follows, and `busy` is low on the next cycle.
- R8: At most `retry_limit` attempts are made. When the last attempt fails, a one-cycle `fail_pulse` is produced and `busy` drops on the next cycle. A limit of 0 fails right after the preload.
- R9: After reset, `busy`, `smp_ready`, `prog_req`, `pass_pulse` and `fail_pulse` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a qualification job |
| n_samples | input | CNT_W | Trace length N |
| retry_limit | input | RETRY_W | Maximum number of attempts L |
| step_offset | input | STEP_W | Back-off K subtracted from the recorded step count |
| step_record | input | STEP_W | Step count recorded when the cell was first found |
| smp_valid | input | 1 | Sample offered |
| smp_bit | input | 1 | Sample value read from the cell |
| smp_ready | output | 1 | Block is collecting samples |
| prog_req | output | 1 | One-cycle request for one partial-program step |
| pass_pulse | output | 1 | Cell qualified |
| fail_pulse | output | 1 | Cell abandoned |
| busy | output | 1 | A job is in progress |

## Verification
The bench builds the block with WIN_LEN = 16, so window limits of 12 and 4 ones are reached within short traces. Traces of 1000 samples place the 98% rejection edge on whole sample counts, with a stuck-high case and a stuck-low case on each side of that edge. Patterns that change from one attempt to the next exercise the retry path. Short traces and a retry limit of zero exercise the boundaries of the window and of the retry loop. Idle cycles on the sample stream check that back-pressure is respected.

// File: rtl/nq_pkg.sv
package nq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PRE,
    S_STEP,
    S_COL,
    S_EVAL
  } nq_state_e;

  localparam int STUCK_PCT  = 98;
  localparam int HI_TENTHS  = 7;
  localparam int LO_TENTHS  = 3;
endpackage

// File: rtl/nq_tally.sv
module nq_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic [CNT_W-1:0] ones,
  output logic [CNT_W-1:0] total
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones  <= '0;
      total <= '0;
    end else if (clr) begin
      ones  <= '0;
      total <= '0;
    end else if (en) begin
      total <= total + CNT_W'(1);
      if (bit_in) ones <= ones + CNT_W'(1);
    end
  end

  // R4: the ones count can never exceed the sample count
  a_r4_ones_le_total: assert property (@(posedge clk) disable iff (!rst_n)
    ones <= total);
endmodule

// File: rtl/nq_window.sv
module nq_window #(
  parameter int W     = 32,
  parameter int SUM_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             bit_in,
  output logic             seen,
  output logic [SUM_W-1:0] win_max,
  output logic [SUM_W-1:0] win_min
);
  localparam logic [SUM_W-1:0] W_V = SUM_W'(W);

  logic [W-1:0]     hist;
  logic [SUM_W-1:0] sum, fill, sum_nx, fill_nx;
  logic             full;

  always_comb begin
    full    = (fill == W_V);
    sum_nx  = sum + SUM_W'(bit_in) - SUM_W'(full & hist[W-1]);
    fill_nx = full ? fill : fill + SUM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      sum     <= '0;
      fill    <= '0;
      seen    <= 1'b0;
      win_max <= '0;
      win_min <= '1;
    end else if (clr) begin
      hist    <= '0;
      sum     <= '0;
      fill    <= '0;
      seen    <= 1'b0;
      win_max <= '0;
      win_min <= '1;
    end else if (en) begin
      hist <= {hist[W-2:0], bit_in};
      sum  <= sum_nx;
      fill <= fill_nx;
      if (fill_nx == W_V) begin
        seen <= 1'b1;
        if (sum_nx > win_max) win_max <= sum_nx;
        if (sum_nx < win_min) win_min <= sum_nx;
      end
    end
  end

  // R5: the window sum never exceeds the number of samples held
  a_r5_sum_within_fill: assert property (@(posedge clk) disable iff (!rst_n)
    sum <= fill);
  // R5: once a full window exists, the tracked extremes are ordered
  a_r5_extremes_ordered: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (win_min <= win_max));
endmodule

// File: rtl/nq_cell_qualify.sv
module nq_cell_qualify
  import nq_pkg::*;
#(
  parameter int WIN_LEN = 32,
  parameter int CNT_W   = 16,
  parameter int RETRY_W = 8,
  parameter int STEP_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CNT_W-1:0]   n_samples,
  input  logic [RETRY_W-1:0] retry_limit,
  input  logic [STEP_W-1:0]  step_offset,
  input  logic [STEP_W-1:0]  step_record,
  input  logic               smp_valid,
  input  logic               smp_bit,
  output logic               smp_ready,
  output logic               prog_req,
  output logic               pass_pulse,
  output logic               fail_pulse,
  output logic               busy
);
  localparam int SUM_W = $clog2(WIN_LEN + 1);
  localparam int PW    = CNT_W + 7;
  localparam int HI_LIM = HI_TENTHS * WIN_LEN;
  localparam int LO_LIM = LO_TENTHS * WIN_LEN;

  nq_state_e          st;
  logic [CNT_W-1:0]   n_q, taken;
  logic [RETRY_W-1:0] l_q, att_q;
  logic [STEP_W-1:0]  pre_q;

  logic               accept, clr_stats;
  logic [CNT_W-1:0]   ones_c, total_c, zeros_c;
  logic               win_seen;
  logic [SUM_W-1:0]   win_max, win_min;
  logic [PW-1:0]      ones_x, zeros_x, lim_x;
  logic               stuck, swing_hi, swing_lo, trace_ok, out_of_tries;

  assign accept    = smp_valid & smp_ready;
  assign clr_stats = (st == S_STEP);

  nq_tally #(.CNT_W(CNT_W)) u_tally (
    .clk(clk), .rst_n(rst_n), .clr(clr_stats), .en(accept), .bit_in(smp_bit),
    .ones(ones_c), .total(total_c)
  );

  nq_window #(.W(WIN_LEN), .SUM_W(SUM_W)) u_window (
    .clk(clk), .rst_n(rst_n), .clr(clr_stats), .en(accept), .bit_in(smp_bit),
    .seen(win_seen), .win_max(win_max), .win_min(win_min)
  );

  always_comb begin
    zeros_c      = total_c - ones_c;
    ones_x       = PW'(ones_c) * PW'(100);
    zeros_x      = PW'(zeros_c) * PW'(100);
    lim_x        = PW'(total_c) * PW'(STUCK_PCT);
    stuck        = (ones_x > lim_x) || (zeros_x > lim_x);
    swing_hi     = (int'(win_max) * 10) > HI_LIM;
    swing_lo     = (int'(win_min) * 10) < LO_LIM;
    trace_ok     = win_seen && !stuck && swing_hi && swing_lo;
    out_of_tries = (att_q == l_q);
  end

  assign busy       = (st != S_IDLE);
  assign smp_ready  = (st == S_COL) && (n_q != '0);
  assign prog_req   = ((st == S_PRE) && (pre_q != '0)) ||
                      ((st == S_STEP) && !out_of_tries);
  assign pass_pulse = (st == S_EVAL) && trace_ok;
  assign fail_pulse = (st == S_STEP) && out_of_tries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      n_q   <= '0;
      l_q   <= '0;
      pre_q <= '0;
      att_q <= '0;
      taken <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          n_q   <= n_samples;
          l_q   <= retry_limit;
          pre_q <= (step_record > step_offset) ? step_record - step_offset : '0;
          att_q <= '0;
          st    <= S_PRE;
        end
        S_PRE: begin
          if (pre_q != '0) pre_q <= pre_q - STEP_W'(1);
          else             st    <= S_STEP;
        end
        S_STEP: begin
          taken <= '0;
          if (out_of_tries) begin
            st <= S_IDLE;
          end else begin
            att_q <= att_q + RETRY_W'(1);
            st    <= S_COL;
          end
        end
        S_COL: begin
          if (n_q == '0) begin
            st <= S_EVAL;
          end else if (accept) begin
            taken <= taken + CNT_W'(1);
            if (taken == n_q - CNT_W'(1)) st <= S_EVAL;
          end
        end
        S_EVAL: st <= trace_ok ? S_IDLE : S_STEP;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2: each preload cycle lowers the remaining preload count by one
  a_r2_preload_down: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PRE && pre_q != '0) |=> (pre_q == $past(pre_q) - STEP_W'(1)));
  // R3: a collection never takes more samples than the trace length
  a_r3_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_COL) |-> (taken < n_q || n_q == '0));
  // R6: pass and fail are never reported together
  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_pulse && fail_pulse));
  // R7: a pass ends the job on the next cycle
  a_r7_pass_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pass_pulse |=> !busy);
  // R8: the attempt counter never passes the retry limit
  a_r8_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (att_q <= l_q));
  // R8: a fail also ends the job on the next cycle
  a_r8_fail_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fail_pulse |=> !busy);
endmodule

// File: tb/nq_cell_qualify_tb.sv
module nq_cell_qualify_tb;
  localparam int PERIOD = 10;
  localparam int W      = 16;
  localparam int NV     = 12;

  typedef struct packed {
    logic [2:0]  kind;
    logic [15:0] prm;
    logic [15:0] n;
    logic [7:0]  l;
    logic [7:0]  k;
    logic [7:0]  rec;
  } vec_t;

  // kinds: 0 square wave of half-period prm; 1 constant one;
  // 2 first prm samples zero then ones; 3 zeros before attempt prm,
  // square of half-period 16 afterwards; 4 first prm samples one then zeros
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'd16, 16'd100,  8'd3, 8'd2, 8'd5},  // R6 pass at first attempt
    '{3'd0, 16'd4,  16'd100,  8'd2, 8'd0, 8'd1},  // R6 no swing, R8 exhaust
    '{3'd1, 16'd0,  16'd64,   8'd1, 8'd5, 8'd2},  // R4 stuck, R2 saturates
    '{3'd3, 16'd2,  16'd80,   8'd4, 8'd1, 8'd1},  // R8 pass on third attempt
    '{3'd3, 16'd3,  16'd80,   8'd3, 8'd0, 8'd0},  // R8 limit hit first
    '{3'd2, 16'd16, 16'd1000, 8'd1, 8'd0, 8'd0},  // R4 98.4% ones rejected
    '{3'd2, 16'd20, 16'd1000, 8'd1, 8'd0, 8'd0},  // R4 exactly 98% kept
    '{3'd4, 16'd16, 16'd1000, 8'd1, 8'd0, 8'd0},  // R4 98.4% zeros rejected
    '{3'd4, 16'd20, 16'd1000, 8'd1, 8'd0, 8'd0},  // R4 exactly 98% zeros kept
    '{3'd0, 16'd16, 16'd15,   8'd2, 8'd0, 8'd0},  // R5 trace shorter than W
    '{3'd0, 16'd16, 16'd16,   8'd1, 8'd0, 8'd0},  // R5 single window
    '{3'd0, 16'd16, 16'd100,  8'd0, 8'd1, 8'd3}   // R8 zero limit
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] n_samples = '0;
  logic [7:0]  retry_limit = '0, step_offset = '0, step_record = '0;
  logic        smp_valid = 1'b0, smp_bit = 1'b0;
  logic        smp_ready, prog_req, pass_pulse, fail_pulse, busy;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  nq_cell_qualify #(.WIN_LEN(W), .CNT_W(16), .RETRY_W(8), .STEP_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_samples(n_samples),
    .retry_limit(retry_limit), .step_offset(step_offset),
    .step_record(step_record), .smp_valid(smp_valid), .smp_bit(smp_bit),
    .smp_ready(smp_ready), .prog_req(prog_req), .pass_pulse(pass_pulse),
    .fail_pulse(fail_pulse), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic gen_bit(input int kind, input int prm, input int idx,
                                   input int att);
    case (kind)
      0: return ((idx / prm) % 2) == 0;
      1: return 1'b1;
      2: return idx >= prm;
      3: return (att < prm) ? 1'b0 : (((idx / 16) % 2) == 0);
      default: return idx < prm;
    endcase
  endfunction

  function automatic bit trace_passes(input int kind, input int prm, input int n,
                                      input int att);
    int ones = 0;
    int mx = -1;
    int mn = W + 1;
    for (int i = 0; i < n; i++) ones += gen_bit(kind, prm, i, att);
    if (ones * 100 > 98 * n || (n - ones) * 100 > 98 * n) return 1'b0;
    if (n < W) return 1'b0;
    for (int j = W - 1; j < n; j++) begin
      int s = 0;
      for (int q = j - W + 1; q <= j; q++) s += gen_bit(kind, prm, q, att);
      if (s > mx) mx = s;
      if (s < mn) mn = s;
    end
    return (mx * 10 > 7 * W) && (mn * 10 < 3 * W);
  endfunction

  task automatic run_vec(input vec_t v, input bit poke);
    int pre_exp, exp_pass, exp_progs;
    int progs = 0;
    int idx = 0;
    int att = 0;
    int cyc = 0;
    int got_pass = 0;
    int got_fail = 0;
    pre_exp  = (v.rec > v.k) ? int'(v.rec) - int'(v.k) : 0;
    exp_pass = 0;
    exp_progs = pre_exp + int'(v.l);
    for (int a = 0; a < int'(v.l); a++) begin
      if (trace_passes(int'(v.kind), int'(v.prm), int'(v.n), a)) begin
        exp_pass = 1;
        exp_progs = pre_exp + a + 1;
        break;
      end
    end
    @(negedge clk);
    n_samples = v.n; retry_limit = v.l; step_offset = v.k; step_record = v.rec;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1 busy after start", busy, 1);
    while (got_pass == 0 && got_fail == 0 && cyc < 60000) begin
      if (prog_req) begin
        progs++;
        idx = 0;
        att = progs - pre_exp - 1;
      end
      if (pass_pulse) got_pass = 1;
      if (fail_pulse) got_fail = 1;
      start = poke && (cyc == 40);
      n_samples = poke ? 16'd1 : v.n;
      smp_valid = (cyc % 5) != 3;
      smp_bit   = gen_bit(int'(v.kind), int'(v.prm), idx, att);
      if (smp_valid && smp_ready) idx++;
      cyc++;
      if (got_pass == 0 && got_fail == 0) @(negedge clk);
    end
    start = 1'b0;
    smp_valid = 1'b0;
    if (cyc >= 60000) check("R8 job finished", 0, 1);
    check("R6 R7 R8 verdict pass", got_pass, exp_pass);
    check("R6 R7 R8 verdict fail", got_fail, 1 - exp_pass);
    check("R2 R3 prog_req count", progs, exp_progs);
    @(negedge clk);
    check("R7 R8 busy low after verdict", busy, 0);
    check("R3 ready low when idle", smp_ready, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(PERIOD * 2 + 1);
    // R9: reset state
    check("R9 busy in reset", busy, 0);
    check("R9 ready in reset", smp_ready, 0);
    check("R9 prog_req in reset", prog_req, 0);
    check("R9 verdicts in reset", pass_pulse | fail_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 busy after reset", busy, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);

    // R1: start during a job is ignored; the original job completes unchanged
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[3], 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule